// File: doc/BRIEF.md
# Saturating Elapsed-Seconds Counter

This block keeps a binary count of elapsed seconds for an interval timer. A one-cycle pulse from the interval divider, arriving once per second, advances the count by one. The count stops at full scale and never rolls over. A host register write carries a 3-bit command field, and exactly one code in that field returns the count to zero. Counting then continues from zero on later pulses.

When a serial read transfer begins, a strobe captures the live count into a snapshot register. The serial interface then fetches the snapshot one byte at a time through a byte index. The snapshot stays fixed for the whole transfer, so the bytes it returns always come from one consistent value, even while the live count keeps moving. The tick source and the bus protocol are outside this block.

Top module: `elapsed_sec_top`

## Requirements
- R1: After reset the live count is zero, and every snapshot byte index below the byte count returns zero.
- R2: A cycle with `tick_i` high, no clear, and a count below full scale makes `count_o` one larger in the following cycle.
- R3: At full scale (all ones, 0xFFFFFF with default parameters) further ticks leave `count_o` at full scale.
- R4: A cycle with `cmd_wr_i` high and `cmd_i` equal to 3'b010 makes `count_o` zero in the following cycle. Later ticks count up again from zero.
- R5: A write with any other command code (3'b000, 3'b001, 3'b011 through 3'b111), or code 3'b010 without `cmd_wr_i`, leaves `count_o` unchanged when no tick is present.
- R6: When a clear and a tick occur in the same cycle, the clear wins and `count_o` becomes zero.
- R7: A cycle with `rd_start_i` high loads the snapshot with the value `count_o` shows in that cycle, before any same-cycle tick or clear takes effect.
- R8: Between read strobes the snapshot does not change, whatever ticks or clears occur.
- R9: `byte_sel_i` picks a snapshot byte, most significant first. Index 0 gives bits 23:16, index 1 gives bits 15:8, and index 2 gives bits 7:0. Index 3 returns all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| cmd_wr_i | input | 1 | Command field write strobe |
| cmd_i | input | 3 | Command field; 3'b010 clears the count |
| rd_start_i | input | 1 | Read transfer start; captures snapshot |
| byte_sel_i | input | SEL_W (2) | Snapshot byte index, 0 = most significant |
| rd_byte_o | output | BYTE_W (8) | Selected snapshot byte |
| count_o | output | CNT_W (24) | Live elapsed-seconds count |

## Verification
A wrong count state shows on `count_o` in the cycle right after the edge that produced it. Because the reference model compares every cycle, an increment that is missed or doubled is caught within one cycle. A counter that wraps is caught on the first tick past full scale. A clear with the wrong priority or the wrong code is caught one cycle after the write. A wrong snapshot only becomes visible through `rd_byte_o`. The bench therefore sweeps the byte index continuously, so a stale, torn or badly ordered snapshot byte appears within four cycles of its capture.

// File: rtl/elapsed_pkg.sv
package elapsed_pkg;

    localparam int CMD_W = 3;

    typedef logic [CMD_W-1:0] cmd_t;

    // Command code that returns the seconds count to zero
    localparam cmd_t CMD_CLEAR = 3'b010;

endpackage

// File: rtl/elapsed_cmd_decode.sv
module elapsed_cmd_decode
    import elapsed_pkg::*;
(
    input  logic cmd_wr_i,
    input  cmd_t cmd_i,
    output logic clr_o
);

    always_comb begin
        clr_o = 1'b0;
        if (cmd_wr_i && (cmd_i == CMD_CLEAR)) begin
            clr_o = 1'b1;
        end
    end

endmodule

// File: rtl/elapsed_sat_counter.sv
module elapsed_sat_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != FULL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/elapsed_snapshot.sv
module elapsed_snapshot #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CNT_W-1:0]  snap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] snap;
    } snap_state_t;

    snap_state_t st_d, st_q;
    logic [BYTE_W-1:0] lane [NBYTES];

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.snap = cnt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Lane 0 carries the most significant byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = st_q.snap[CNT_W-1-g*BYTE_W -: BYTE_W];
    end

    always_comb begin
        byte_o = '1;
        for (int i = 0; i < NBYTES; i++) begin
            if (sel_i == SEL_W'(i)) begin
                byte_o = lane[i];
            end
        end
    end

    assign snap_o = st_q.snap;

endmodule

// File: rtl/elapsed_sec_top.sv
module elapsed_sec_top
    import elapsed_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cmd_wr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              rd_start_i,
    input  logic [SEL_W-1:0]  byte_sel_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [CNT_W-1:0]  count_o
);

    logic             clr_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] snap_w;

    elapsed_cmd_decode u_dec (
        .cmd_wr_i (cmd_wr_i),
        .cmd_i    (cmd_i),
        .clr_o    (clr_w)
    );

    elapsed_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_w),
        .tick_i (tick_i),
        .cnt_o  (cnt_w)
    );

    elapsed_snapshot #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_snap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (rd_start_i),
        .cnt_i  (cnt_w),
        .sel_i  (byte_sel_i),
        .byte_o (rd_byte_o),
        .snap_o (snap_w)
    );

    assign count_o = cnt_w;

endmodule

// File: rtl/elapsed_sec_chk.sv
module elapsed_sec_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             cmd_wr_i,
    input logic [2:0]       cmd_i,
    input logic             rd_start_i,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] snap_w
);

    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic clear_req;
    assign clear_req = cmd_wr_i && (cmd_i == 3'b010);

    AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clear_req && count_o != FULL) |=> (count_o == $past(count_o) + 1'b1)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == FULL && !clear_req) |=> (count_o == FULL)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_req |=> (count_o == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clear_req) |=> $stable(count_o)); // R5

    AST_CLEAR_BEATS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_req && tick_i) |=> (count_o == '0)); // R6

    AST_SNAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_start_i |=> (snap_w == $past(count_o))); // R7

    AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_start_i |=> $stable(snap_w)); // R8

endmodule

bind elapsed_sec_top elapsed_sec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .rd_start_i (rd_start_i),
    .count_o    (count_o),
    .snap_w     (snap_w)
);

// File: tb/elapsed_sec_top_test.sv
module elapsed_sec_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 12;
    localparam int BW   = 4;
    localparam int NB   = CW / BW;
    localparam int SW   = $clog2(NB + 1);
    localparam int MAXV = (1 << CW) - 1;
    localparam int BMSK = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [2:0]    cmd = 3'b000;
    logic          rd_start = 1'b0;
    logic [SW-1:0] bsel = '0;
    logic [BW-1:0] rd_byte;
    logic [CW-1:0] count;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    int m_snap = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    elapsed_sec_top #(.CNT_W(CW), .BYTE_W(BW)) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .cmd_wr_i   (cmd_wr),
        .cmd_i      (cmd),
        .rd_start_i (rd_start),
        .byte_sel_i (bsel),
        .rd_byte_o  (rd_byte),
        .count_o    (count)
    );

    function automatic int exp_byte(int snap, int sel);
        if (sel < NB) return (snap >> ((NB - 1 - sel) * BW)) & BMSK;
        return BMSK;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(bit t, bit w, logic [2:0] c, bit r, string ctag, string btag);
        tick = t; cmd_wr = w; cmd = c; rd_start = r;
        bsel = SW'(cyc % 4);
        @(posedge clk);
        if (r) m_snap = m_cnt;
        if (w && c == 3'b010) m_cnt = 0;
        else if (t && m_cnt < MAXV) m_cnt++;
        @(negedge clk);
        cyc++;
        check(ctag, int'(count), m_cnt);
        check(btag, int'(rd_byte), exp_byte(m_snap, int'(bsel)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", int'(count), 0);
        for (int s = 0; s < NB; s++) begin
            bsel = SW'(s);
            #1 check("R1 byte", int'(rd_byte), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: sparse ticks
        for (int i = 0; i < 24; i++) step(i % 3 == 0, 0, 3'b000, 0, "R2", "R9");
        // R2: back-to-back ticks
        for (int i = 0; i < 10; i++) step(1, 0, 3'b000, 0, "R2", "R9");

        // R5: every non-clearing code, and the clear code without strobe
        for (int k = 0; k < 8; k++) begin
            if (k != 2) step(0, 1, 3'(k), 0, "R5", "R9");
        end
        step(0, 0, 3'b010, 0, "R5", "R9");
        step(1, 1, 3'b111, 0, "R5 tick with code 111", "R9");

        // R4: clear then resume counting
        step(0, 1, 3'b010, 0, "R4", "R9");
        for (int i = 0; i < 6; i++) step(1, 0, 3'b000, 0, "R4 resume", "R9");

        // R6: clear and tick together
        step(1, 1, 3'b010, 0, "R6", "R9");
        for (int i = 0; i < 5; i++) step(1, 0, 3'b000, 0, "R6 after", "R9");

        // R7: capture, including with same-cycle tick and clear
        step(1, 0, 3'b000, 1, "R7", "R7");
        for (int i = 0; i < 8; i++) step(1, 0, 3'b000, 0, "R8", "R8");
        step(0, 1, 3'b010, 0, "R8 clear", "R8");
        for (int i = 0; i < 8; i++) step(i % 2 == 0, 0, 3'b000, 0, "R8", "R8");
        step(1, 1, 3'b010, 1, "R7 with clear", "R7");
        for (int i = 0; i < 4; i++) step(1, 0, 3'b000, 0, "R8", "R8");
        step(0, 0, 3'b000, 1, "R7 idle", "R7");
        for (int i = 0; i < 4; i++) step(1, 0, 3'b000, 0, "R8", "R8");

        // R3: run to full scale and beyond
        for (int i = 0; i < MAXV + 12; i++) step(1, 0, 3'b000, 0, "R3", "R9");
        check("R3 at full", int'(count), MAXV);
        step(1, 0, 3'b000, 1, "R3 capture", "R7");
        for (int i = 0; i < 8; i++) step(1, 0, 3'b101, 0, "R3", "R9");
        step(1, 1, 3'b010, 0, "R4 from full", "R9");
        for (int i = 0; i < 3; i++) step(1, 0, 3'b000, 0, "R4 resume", "R9");

        finish_run();
    end

endmodule